// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one general-purpose I/O port of NPINS pins (32 by default). A small register file, reached over a simple single-cycle write bus with a combinational read path, holds the pin output values, the output drive enables, per-pin interrupt routing and enables, and a two-bit interrupt mode for each pin. Every writable register has three write addresses: one that replaces the value, one that ORs a mask in, and one that clears the bits named by a mask. Software can therefore change single bits without a read-modify-write sequence.

Pad inputs pass through a multi-flop synchroniser. The synchronised levels can be read back, and they feed a per-pin detector. Depending on its mode, the detector reports a rising edge, a falling edge, a high level or a low level. Detected events set sticky status bits, which only the clear address of the status register can drop. A single interrupt line is high whenever an enabled pin has its status bit set. The external pad cell drives the pin from `pad_out` where `pad_oe` is 1 and leaves it high-impedance elsewhere.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `pad_oe` is all zeros.
- R2: Byte address bits [6:4] select the register: 0 data-out, 1 data-in, 2 output-enable, 3 interrupt-route, 4 interrupt-enable, 5 level-select, 6 polarity, 7 status. Bits [3:2] select the write action: 0 replaces the value, 1 ORs `wdata` in, 2 clears the bits that are 1 in `wdata`, and 3 has no effect. A write with address bits [1:0] not zero, or with any address bit above bit 6 set, has no effect. A read returns the selected register whatever the values of bits [3:0].
- R3: A data-in read returns the pad levels through a two-flop synchroniser. A pad change is visible on the second clock edge after it and not on the first. Writes to data-in have no effect.
- R4: `pad_out` equals the data-out register and `pad_oe` equals the output-enable register.
- R5: The interrupt mode of a pin is written as {polarity bit, level bit}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. An edge event sets the status bit on the third clock edge after the pad changes and not on the second. An edge in the opposite direction sets nothing.
- R6: Status bits are sticky. Only a clear-action write to the status register drops them. Replace-action and OR-action writes to status have no effect.
- R7: While a level-sensitive pin holds its active level, its status bit is set again on every cycle. A clear-action write in the same cycle as a set event leaves the bit set.
- R8: A pin whose interrupt-route bit is 0 never sets its status bit.
- R9: `irq` is high exactly when some bit of (status AND interrupt-enable) is 1. Interrupt-enable resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | ADDR_W | Byte address of the register and write action |
| wdata | input | NPINS | Write data or bit mask |
| rdata | output | NPINS | Combinational read data for `addr` |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Output value for each pad |
| pad_oe | output | NPINS | Per-pad drive enable (0 = high-impedance) |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench builds the port with its default parameters: 32 pins, a seven-bit address and a two-stage synchroniser. With these values the lowest and the highest pin, the full-width alias masks and the exact two- and three-edge latencies can all be checked against fixed cycle counts. Each of the four interrupt modes is exercised on its own pin. The same-cycle clash between a clear write and a level event occurs naturally whenever status is cleared while a level pin stays active.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register selected by byte address bits [6:4]
    typedef enum logic [2:0] {
        K_DOUT  = 3'd0,
        K_DIN   = 3'd1,
        K_OE    = 3'd2,
        K_ROUTE = 3'd3,
        K_IEN   = 3'd4,
        K_LVL   = 3'd5,
        K_POL   = 3'd6,
        K_STAT  = 3'd7
    } reg_kind_e;

    // Write action selected by byte address bits [3:2]
    typedef enum logic [1:0] {
        A_WRITE = 2'd0,
        A_SET   = 2'd1,
        A_CLEAR = 2'd2,
        A_NONE  = 2'd3
    } wr_action_e;

    localparam int KIND_LSB   = 4;
    localparam int ACTION_LSB = 2;
    localparam int DECODE_W   = 7;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] prev_o
);

    logic [NPINS-1:0] stage_q [STAGES];
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pad_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    // One cycle of history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] sync_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] route_i,
    input  logic [NPINS-1:0] lvl_i,
    input  logic [NPINS-1:0] pol_i,
    output logic [NPINS-1:0] evt_o
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise;
        logic fall;
        logic hit;
        always_comb begin
            rise = sync_i[i] & ~prev_i[i];
            fall = ~sync_i[i] & prev_i[i];
            if (lvl_i[i]) hit = (sync_i[i] == pol_i[i]);
            else          hit = pol_i[i] ? rise : fall;
            evt_o[i] = route_i[i] & hit;
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] route;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] stat;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] sync_lvl, prev_lvl, evt, stat_clr;
    reg_kind_e        kind;
    wr_action_e       act;
    logic             addr_ok;

    function automatic logic [NPINS-1:0] apply_action(
        input wr_action_e       a,
        input logic [NPINS-1:0] cur,
        input logic [NPINS-1:0] w
    );
        case (a)
            A_WRITE: return w;
            A_SET:   return cur | w;
            A_CLEAR: return cur & ~w;
            default: return cur;
        endcase
    endfunction

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_o (sync_lvl),
        .prev_o (prev_lvl)
    );

    gpio_detect #(.NPINS(NPINS)) u_detect (
        .sync_i  (sync_lvl),
        .prev_i  (prev_lvl),
        .route_i (r_q.route),
        .lvl_i   (r_q.lvl),
        .pol_i   (r_q.pol),
        .evt_o   (evt)
    );

    always_comb begin
        kind    = reg_kind_e'(addr[KIND_LSB +: 3]);
        act     = wr_action_e'(addr[ACTION_LSB +: 2]);
        addr_ok = (addr[1:0] == 2'b00) && ((addr >> DECODE_W) == '0);
        r_d      = r_q;
        stat_clr = '0;
        if (wr_en && addr_ok) begin
            case (kind)
                K_DOUT:  r_d.dout  = apply_action(act, r_q.dout,  wdata);
                K_OE:    r_d.oe    = apply_action(act, r_q.oe,    wdata);
                K_ROUTE: r_d.route = apply_action(act, r_q.route, wdata);
                K_IEN:   r_d.ien   = apply_action(act, r_q.ien,   wdata);
                K_LVL:   r_d.lvl   = apply_action(act, r_q.lvl,   wdata);
                K_POL:   r_d.pol   = apply_action(act, r_q.pol,   wdata);
                K_STAT:  if (act == A_CLEAR) stat_clr = wdata;
                default: ;
            endcase
        end
        // set events take priority over a clear in the same cycle
        r_d.stat = (r_q.stat & ~stat_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (kind)
            K_DOUT:  rdata = r_q.dout;
            K_DIN:   rdata = sync_lvl;
            K_OE:    rdata = r_q.oe;
            K_ROUTE: rdata = r_q.route;
            K_IEN:   rdata = r_q.ien;
            K_LVL:   rdata = r_q.lvl;
            K_POL:   rdata = r_q.pol;
            default: rdata = r_q.stat;
        endcase
    end

    assign pad_out = r_q.dout;
    assign pad_oe  = r_q.oe;
    assign irq     = |(r_q.stat & r_q.ien);

    // ---------------- assertions ----------------
    logic [NPINS-1:0] lvl_active;
    assign lvl_active = r_q.route & r_q.lvl & ~(sync_lvl ^ r_q.pol);

    // R2: an OR-action write to data-out leaves every written bit set
    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && kind == K_DOUT && act == A_SET)
        |=> ((r_q.dout & $past(wdata)) == $past(wdata)));

    // R5: an edge-mode event needs the synchronised level to have changed
    a_r5_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~r_q.lvl & ~(sync_lvl ^ prev_lvl)) == '0));

    // R6: without a clear write to status, no status bit drops
    a_r6_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_ok && kind == K_STAT && act == A_CLEAR)
        |=> ((r_q.stat & $past(r_q.stat)) == $past(r_q.stat)));

    // R7: an active level always leaves its status bit set next cycle
    a_r7_level_reassert: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.stat & $past(lvl_active)) == $past(lvl_active)));

    // R8: unrouted pins never raise their status bit
    a_r8_route_gate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.stat & ~$past(r_q.stat) & ~$past(r_q.route)) == '0));

    // R9: no interrupt while all enables are off
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ien == '0) |-> !irq);

endmodule

// File: tb/gpio_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_irq_port_tb;

    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [6:0]   addr = '0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic         irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_port u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // register codes (R2)
    localparam logic [2:0] DOUT = 3'd0, DIN = 3'd1, OE = 3'd2, ROUTE = 3'd3,
                           IEN = 3'd4, LVL = 3'd5, POL = 3'd6, STAT = 3'd7;
    localparam logic [1:0] WR = 2'd0, SETA = 2'd1, CLRA = 2'd2, NOP = 2'd3;

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] k, input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        addr = {k, a, 2'b00}; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] k, output logic [N-1:0] v);
        addr = {k, 2'b00, 2'b00};
        #1 v = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pad_step(input logic [N-1:0] v, input logic [N-1:0] exp, input string tag);
        logic [N-1:0] s;
        @(negedge clk);
        pad_in = v;
        cyc(3);
        rd(STAT, s);
        check(tag, s, exp);
    endtask

    task automatic t_reset;
        logic [N-1:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(3'(k), v);
            check("R1 register reset value", v, '0);
        end
        check("R1 irq low", {31'd0, irq}, '0);
        check("R1 pad_oe zero", pad_oe, '0);
    endtask

    task automatic t_alias;
        logic [N-1:0] v;
        wr(DOUT, WR, 32'hA5A5_0F0F);
        rd(DOUT, v); check("R2 replace write", v, 32'hA5A5_0F0F);
        wr(DOUT, SETA, 32'hF000_0000);
        rd(DOUT, v); check("R2 OR write", v, 32'hF5A5_0F0F);
        wr(DOUT, CLRA, 32'h0000_000F);
        rd(DOUT, v); check("R2 clear write", v, 32'hF5A5_0F00);
        wr(DOUT, NOP, 32'h0);
        rd(DOUT, v); check("R2 action 3 ignored", v, 32'hF5A5_0F00);
        @(negedge clk);
        addr = 7'h01; wdata = '0; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        rd(DOUT, v); check("R2 misaligned write ignored", v, 32'hF5A5_0F00);
        wr(OE, WR, 32'h0000_FFFF);
        check("R4 pad_oe follows register", pad_oe, 32'h0000_FFFF);
        check("R4 pad_out follows data-out", pad_out, 32'hF5A5_0F00);
    endtask

    task automatic t_din;
        logic [N-1:0] v;
        @(negedge clk);
        pad_in = 32'h8000_0001;
        cyc(1);
        rd(DIN, v); check("R3 not visible after one edge", v, '0);
        cyc(1);
        rd(DIN, v); check("R3 visible after two edges", v, 32'h8000_0001);
        wr(DIN, WR, 32'h0);
        rd(DIN, v); check("R3 write to data-in ignored", v, 32'h8000_0001);
        @(negedge clk);
        pad_in = '0;
        cyc(3);
    endtask

    task automatic t_modes;
        logic [N-1:0] v;
        // pin0 rising (10), pin1 falling (00), pin2 high (11), pin3 low (01)
        @(negedge clk); pad_in = 32'hA; cyc(3);
        wr(LVL, WR, 32'hC);
        wr(POL, WR, 32'h5);
        wr(IEN, WR, '1);
        wr(ROUTE, WR, 32'hF);
        wr(STAT, CLRA, '1);
        rd(STAT, v); check("R5 quiet when no pin is active", v, '0);
        // rising edge on pin0 with latency check
        @(negedge clk); pad_in = 32'hB;
        cyc(2);
        rd(STAT, v); check("R5 rise not set after two edges", v, '0);
        cyc(1);
        rd(STAT, v); check("R5 rise set after three edges", v, 32'h1);
        check("R9 irq with enabled status", {31'd0, irq}, 32'h1);
        // R6: replace and OR writes leave status alone
        wr(STAT, WR, 32'h0);
        rd(STAT, v); check("R6 replace write ignored", v, 32'h1);
        wr(STAT, SETA, 32'h10);
        rd(STAT, v); check("R6 OR write ignored", v, 32'h1);
        // R9: enable gates irq
        wr(IEN, CLRA, 32'h1);
        check("R9 irq low when pin disabled", {31'd0, irq}, '0);
        wr(IEN, SETA, 32'h1);
        check("R9 irq back when re-enabled", {31'd0, irq}, 32'h1);
        wr(STAT, CLRA, 32'h1);
        rd(STAT, v); check("R6 clear write drops status", v, '0);
        check("R9 irq low after clear", {31'd0, irq}, '0);
        pad_step(32'hA, 32'h0, "R5 falling edge ignored in rising mode");
        pad_step(32'h8, 32'h2, "R5 falling edge on pin1");
        wr(STAT, CLRA, '1);
        pad_step(32'hC, 32'h4, "R5 high level on pin2");
        wr(STAT, CLRA, 32'h4);
        rd(STAT, v); check("R7 level wins over clear", v, 32'h4);
        pad_step(32'h8, 32'h4, "R6 status sticky after level ends");
        wr(STAT, CLRA, '1);
        pad_step(32'h0, 32'h8, "R5 low level on pin3");
        @(negedge clk); pad_in = 32'h8; cyc(3);
        wr(STAT, CLRA, '1);
        rd(STAT, v); check("R5 low level cleared once released", v, '0);
    endtask

    task automatic t_route;
        logic [N-1:0] v;
        wr(ROUTE, CLRA, 32'h1);
        pad_step(32'h9, 32'h0, "R8 unrouted rising edge ignored");
        check("R8 irq stays low", {31'd0, irq}, '0);
        // top pin, rising edge mode
        wr(POL, SETA, 32'h8000_0000);
        wr(ROUTE, SETA, 32'h8000_0000);
        rd(STAT, v); check("R8 no stray status", v, '0);
        pad_step(32'h8000_0009, 32'h8000_0000, "R5 rising edge on top pin");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_alias();
        t_din();
        t_modes();
        t_route();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule